// File: doc/BRIEF.md
# Iterative Radix-2 FFT Engine

This block computes a discrete Fourier transform of a block of complex 16-bit samples using one shared complex butterfly. A start pulse latches the run settings: the transform size as a base-2 logarithm, the direction (forward or inverse) and a signed output gain shift. The engine then accepts exactly N samples on a valid/ready input. Each sample is multiplied by a real weighting coefficient before it is stored, and it is stored at the bit-reversed address so that the results come out in natural order. The engine then runs log2(N) decimation-in-time stages of N/2 butterflies each and streams the N results out on consecutive cycles.

The weighting coefficients and the twiddle factors sit in two tables that are written through a configuration port. Twiddle table entry t holds the forward factor for the angle 2*pi*t/Nmax. Stage s (counting from 0) uses entry k*(Nmax/2^(s+1)) for butterfly offset k. The inverse transform conjugates the factor as it is read, so a single table serves both directions. Every butterfly halves its outputs, so the raw result is the DFT divided by N. The gain shift then scales that result.

Top module: `fft_engine`

## Requirements
- R1: After reset, busy, in_ready, out_valid and done are all low.
- R2: After a start pulse in idle, in_ready stays high until exactly N samples have been accepted, and in_valid pulses on which in_ready is low change nothing.
- R3: Forward output k equals (1/N) * sum over n of x[n]*exp(-j*2*pi*n*k/N). Twiddle table entry t holds round(16384*cos(2*pi*t/Nmax)) in its real half and round(-16384*sin(2*pi*t/Nmax)) in its imaginary half.
- R4: With inverse set at start, output k equals (1/N) * sum over n of x[n]*exp(+j*2*pi*n*k/N), computed from the same twiddle table.
- R5: Each of the log2(N) stages scales by an arithmetic right shift of one, so an impulse of amplitude A at sample 0 yields A/N in every bin.
- R6: Input sample n (arrival order) is multiplied by window entry n, which has 14 fraction bits (16384 is unity), before it is stored.
- R7: The gain is a 5-bit two's-complement shift g. For g >= 0 the result is shifted left by g and saturated to [-32768, 32767]. For g < 0 it is shifted right arithmetically by -g.
- R8: log_len is latched at start. A value of 0 runs N = 2, and a value above MAX_LOG runs N = 2^MAX_LOG.
- R9: The N results appear on N consecutive out_valid cycles in natural bin order. done is high for one cycle, in the cycle after the last result, and busy is low in that cycle.
- R10: A start pulse while busy is ignored, and the running transform keeps its length, direction and gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 writes the window table, 1 writes the twiddle table |
| cfg_addr | input | MAX_LOG | Table entry (twiddle uses the low MAX_LOG-1 bits) |
| cfg_re | input | TW_W | Window value, or twiddle real part |
| cfg_im | input | TW_W | Twiddle imaginary part |
| start | input | 1 | Begins a run when idle |
| log_len | input | clog2(MAX_LOG+1) | log2 of the transform length |
| inverse | input | 1 | 1 selects the inverse transform |
| gain | input | GAIN_W | Signed output shift |
| in_valid | input | 1 | Input sample valid |
| in_re | input | DW | Input real part |
| in_im | input | DW | Input imaginary part |
| in_ready | output | 1 | Engine is accepting samples |
| out_valid | output | 1 | Result valid |
| out_re | output | DW | Result real part |
| out_im | output | DW | Result imaginary part |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest situation to reach is an exact check of the multi-stage butterfly path, because most twiddles are rounded and per-stage halving truncates. The stimulus therefore uses cases where the arithmetic loses nothing. For length-4 transforms, every factor is ±1 or ±j, and inputs that are multiples of 4 make each stage's halving exact. For length-16 transforms, impulse and constant inputs meet only unity factors. A second hard case is a start request arriving in the middle of loading with a different length. The stimulus raises start after two samples and then confirms that the run keeps its original length and values. Length clamping and gain saturation are reached with out-of-range log_len values and large length-2 inputs.

// File: rtl/fft_pkg.sv
package fft_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RD,
      ST_WR,
      ST_OUT,
      ST_FIN
   } fft_state_e;

   localparam int REV_MAX = 12;

   // mirror the low nb bits of v
   function automatic logic [REV_MAX-1:0] bit_rev(input logic [REV_MAX-1:0] v,
                                                  input int unsigned nb);
      logic [REV_MAX-1:0] r;
      r = '0;
      for (int i = 0; i < REV_MAX; i++) begin
         if (i < int'(nb)) r[int'(nb) - 1 - i] = v[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/fft_win_mul.sv
module fft_win_mul #(
   parameter int DW   = 16,
   parameter int TW_W = 16
) (
   input  logic signed [DW-1:0]   x,
   input  logic signed [TW_W-1:0] w,
   output logic signed [DW-1:0]   y
);
   localparam int PW   = DW + TW_W + 1;
   localparam int FRAC = TW_W - 2;
   localparam logic signed [PW-1:0] HI = PW'((1 << (DW - 1)) - 1);
   localparam logic signed [PW-1:0] LO = -HI - PW'(1);

   logic signed [PW-1:0] prod;

   always_comb begin
      prod = (PW'(x) * PW'(w)) >>> FRAC;
      if (prod > HI)      y = DW'(HI);
      else if (prod < LO) y = DW'(LO);
      else                y = DW'(prod);
   end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
   parameter int DW   = 16,
   parameter int TW_W = 16
) (
   input  logic signed [DW-1:0]   a_re,
   input  logic signed [DW-1:0]   a_im,
   input  logic signed [DW-1:0]   b_re,
   input  logic signed [DW-1:0]   b_im,
   input  logic signed [TW_W-1:0] w_re,
   input  logic signed [TW_W-1:0] w_im,
   output logic signed [DW-1:0]   y0_re,
   output logic signed [DW-1:0]   y0_im,
   output logic signed [DW-1:0]   y1_re,
   output logic signed [DW-1:0]   y1_im
);
   localparam int PW   = DW + TW_W + 2;
   localparam int FRAC = TW_W - 2;
   localparam logic signed [PW-1:0] HI = PW'((1 << (DW - 1)) - 1);
   localparam logic signed [PW-1:0] LO = -HI - PW'(1);

   function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
      if (v > HI)      return DW'(HI);
      else if (v < LO) return DW'(LO);
      else             return DW'(v);
   endfunction

   logic signed [PW-1:0] pr, pi, s0r, s0i, s1r, s1i;

   always_comb begin
      pr  = (PW'(b_re) * PW'(w_re) - PW'(b_im) * PW'(w_im)) >>> FRAC;
      pi  = (PW'(b_re) * PW'(w_im) + PW'(b_im) * PW'(w_re)) >>> FRAC;
      s0r = (PW'(a_re) + pr) >>> 1;
      s0i = (PW'(a_im) + pi) >>> 1;
      s1r = (PW'(a_re) - pr) >>> 1;
      s1i = (PW'(a_im) - pi) >>> 1;
      y0_re = clip(s0r);
      y0_im = clip(s0i);
      y1_re = clip(s1r);
      y1_im = clip(s1i);
   end
endmodule

// File: rtl/fft_gain_sat.sv
module fft_gain_sat #(
   parameter int DW     = 16,
   parameter int GAIN_W = 5
) (
   input  logic signed [DW-1:0]     x,
   input  logic signed [GAIN_W-1:0] g,
   output logic signed [DW-1:0]     y
);
   localparam int EW = DW + (1 << (GAIN_W - 1)) + 1;
   localparam logic signed [EW-1:0] HI = EW'((1 << (DW - 1)) - 1);
   localparam logic signed [EW-1:0] LO = -HI - EW'(1);

   logic [GAIN_W-1:0]    amt;
   logic signed [EW-1:0] v;

   always_comb begin
      amt = g[GAIN_W-1] ? ($unsigned(GAIN_W'(0)) - $unsigned(g)) : $unsigned(g);
      if (g[GAIN_W-1]) v = EW'(x) >>> amt;
      else             v = EW'(x) <<< amt;
      if (v > HI)      y = DW'(HI);
      else if (v < LO) y = DW'(LO);
      else             y = DW'(v);
      // shifting and clipping never flip the sign
      assert_gain_sign_R7: assert (y[DW-1] == x[DW-1]);
   end
endmodule

// File: rtl/fft_engine.sv
module fft_engine #(
   parameter int DW      = 16,
   parameter int MAX_LOG = 8,
   parameter int TW_W    = 16,
   parameter int GAIN_W  = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic                              cfg_sel,
   input  logic [MAX_LOG-1:0]                cfg_addr,
   input  logic signed [TW_W-1:0]            cfg_re,
   input  logic signed [TW_W-1:0]            cfg_im,
   input  logic                              start,
   input  logic [$clog2(MAX_LOG+1)-1:0]      log_len,
   input  logic                              inverse,
   input  logic signed [GAIN_W-1:0]          gain,
   input  logic                              in_valid,
   input  logic signed [DW-1:0]              in_re,
   input  logic signed [DW-1:0]              in_im,
   output logic                              in_ready,
   output logic                              out_valid,
   output logic signed [DW-1:0]              out_re,
   output logic signed [DW-1:0]              out_im,
   output logic                              busy,
   output logic                              done
);
   import fft_pkg::*;

   localparam int NMAX  = 1 << MAX_LOG;
   localparam int HALF  = NMAX / 2;
   localparam int AW    = MAX_LOG;
   localparam int LOG_W = $clog2(MAX_LOG + 1);

   if (MAX_LOG < 2 || MAX_LOG > REV_MAX) begin : g_bad_len
      $error("MAX_LOG must lie in 2..12");
   end
   if (TW_W < 4 || DW < 4) begin : g_bad_width
      $error("DW and TW_W must be at least 4");
   end
   if (GAIN_W < 2 || GAIN_W > 6) begin : g_bad_gain
      $error("GAIN_W must lie in 2..6");
   end

   // storage
   logic signed [DW-1:0]   wk_re [NMAX];
   logic signed [DW-1:0]   wk_im [NMAX];
   logic signed [TW_W-1:0] win_mem [NMAX];
   logic signed [TW_W-1:0] tw_re [HALF];
   logic signed [TW_W-1:0] tw_im [HALF];

   // run state
   fft_state_e               st;
   logic [LOG_W-1:0]         log_q;
   logic                     inv_q;
   logic signed [GAIN_W-1:0] gain_q;
   logic [AW-1:0]            cnt;
   logic [LOG_W-1:0]         stg;
   logic [AW-1:0]            bf;
   logic [AW-1:0]            top_q, bot_q;
   logic signed [DW-1:0]     ar, ai, br, bi;
   logic signed [TW_W-1:0]   wr, wi;

   // derived sizes and addresses
   logic [AW:0]      n_len;
   logic [AW-1:0]    n_m1, h_m1, half, k_off, top_a, bot_a;
   logic [AW-2:0]    t_idx;
   logic [AW-1:0]    ld_addr;
   logic [LOG_W-1:0] lg_clamp;

   always_comb begin
      n_len   = (AW+1)'(1) << log_q;
      n_m1    = AW'(n_len - (AW+1)'(1));
      h_m1    = AW'((n_len >> 1) - (AW+1)'(1));
      half    = AW'(1) << stg;
      k_off   = bf & (half - AW'(1));
      top_a   = ((bf >> stg) << (stg + LOG_W'(1))) | k_off;
      bot_a   = top_a | half;
      t_idx   = (AW-1)'(k_off << (LOG_W'(MAX_LOG - 1) - stg));
      ld_addr = AW'(bit_rev(REV_MAX'(cnt), int'(log_q)));
      if (log_len == '0)                  lg_clamp = LOG_W'(1);
      else if (log_len > LOG_W'(MAX_LOG)) lg_clamp = LOG_W'(MAX_LOG);
      else                                lg_clamp = log_len;
   end

   // per-lane window multiply and output gain
   logic signed [DW-1:0] in_lane  [2];
   logic signed [DW-1:0] win_lane [2];
   logic signed [DW-1:0] rd_lane  [2];
   logic signed [DW-1:0] gn_lane  [2];

   assign in_lane[0] = in_re;
   assign in_lane[1] = in_im;
   assign rd_lane[0] = wk_re[cnt];
   assign rd_lane[1] = wk_im[cnt];

   for (genvar gi = 0; gi < 2; gi++) begin : g_lane
      fft_win_mul #(.DW(DW), .TW_W(TW_W)) win_i (
         .x(in_lane[gi]), .w(win_mem[cnt]), .y(win_lane[gi]));
      fft_gain_sat #(.DW(DW), .GAIN_W(GAIN_W)) gain_i (
         .x(rd_lane[gi]), .g(gain_q), .y(gn_lane[gi]));
   end

   logic signed [DW-1:0] y0r, y0i, y1r, y1i;

   fft_bfly #(.DW(DW), .TW_W(TW_W)) bfly_i (
      .a_re(ar), .a_im(ai), .b_re(br), .b_im(bi), .w_re(wr), .w_im(wi),
      .y0_re(y0r), .y0_im(y0i), .y1_re(y1r), .y1_im(y1i));

   // table and working-memory writes
   always_ff @(posedge clk) begin
      if (cfg_we) begin
         if (cfg_sel) begin
            tw_re[cfg_addr[AW-2:0]] <= cfg_re;
            tw_im[cfg_addr[AW-2:0]] <= cfg_im;
         end else begin
            win_mem[cfg_addr] <= cfg_re;
         end
      end
      if (st == ST_LOAD && in_valid) begin
         wk_re[ld_addr] <= win_lane[0];
         wk_im[ld_addr] <= win_lane[1];
      end else if (st == ST_WR) begin
         wk_re[top_q] <= y0r;
         wk_im[top_q] <= y0i;
         wk_re[bot_q] <= y1r;
         wk_im[bot_q] <= y1i;
      end
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         log_q     <= LOG_W'(1);
         inv_q     <= 1'b0;
         gain_q    <= '0;
         cnt       <= '0;
         stg       <= '0;
         bf        <= '0;
         top_q     <= '0;
         bot_q     <= '0;
         ar        <= '0;
         ai        <= '0;
         br        <= '0;
         bi        <= '0;
         wr        <= '0;
         wi        <= '0;
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               log_q  <= lg_clamp;
               inv_q  <= inverse;
               gain_q <= gain;
               cnt    <= '0;
               stg    <= '0;
               bf     <= '0;
               st     <= ST_LOAD;
            end
            ST_LOAD: if (in_valid) begin
               cnt <= cnt + AW'(1);
               if (cnt == n_m1) st <= ST_RD;
            end
            ST_RD: begin
               ar    <= wk_re[top_a];
               ai    <= wk_im[top_a];
               br    <= wk_re[bot_a];
               bi    <= wk_im[bot_a];
               wr    <= tw_re[t_idx];
               wi    <= inv_q ? -tw_im[t_idx] : tw_im[t_idx];
               top_q <= top_a;
               bot_q <= bot_a;
               st    <= ST_WR;
            end
            ST_WR: begin
               st <= ST_RD;
               if (bf == h_m1) begin
                  bf <= '0;
                  if (stg == log_q - LOG_W'(1)) begin
                     cnt <= '0;
                     st  <= ST_OUT;
                  end else begin
                     stg <= stg + LOG_W'(1);
                  end
               end else begin
                  bf <= bf + AW'(1);
               end
            end
            ST_OUT: begin
               out_valid <= 1'b1;
               out_re    <= gn_lane[0];
               out_im    <= gn_lane[1];
               cnt       <= cnt + AW'(1);
               if (cnt == n_m1) st <= ST_FIN;
            end
            ST_FIN: begin
               out_valid <= 1'b0;
               done      <= 1'b1;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign in_ready = (st == ST_LOAD);
   assign busy     = (st != ST_IDLE);

   // checks
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!in_ready && !out_valid));
   assert_load_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> ((AW+1)'(cnt) < n_len));
   assert_stage_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD) |-> (stg < log_q && log_q >= LOG_W'(1) && log_q <= LOG_W'(MAX_LOG)));
   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(out_valid) && !out_valid && !busy));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(log_q) && $stable(inv_q) && $stable(gain_q)));
endmodule

// File: tb/fft_engine_tb_top.sv
module fft_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int ML = 4;
   localparam int NM = 1 << ML;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [ML-1:0] cfg_addr = '0;
   logic signed [15:0] cfg_re = '0, cfg_im = '0;
   logic start = 1'b0;
   logic [2:0] log_len = '0;
   logic inverse = 1'b0;
   logic signed [4:0] gain = '0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_re = '0, in_im = '0;
   logic in_ready, out_valid, busy, done;
   logic signed [DW-1:0] out_re, out_im;

   fft_engine #(.DW(DW), .MAX_LOG(ML), .TW_W(16), .GAIN_W(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_addr(cfg_addr), .cfg_re(cfg_re), .cfg_im(cfg_im), .start(start),
      .log_len(log_len), .inverse(inverse), .gain(gain), .in_valid(in_valid),
      .in_re(in_re), .in_im(in_im), .in_ready(in_ready), .out_valid(out_valid),
      .out_re(out_re), .out_im(out_im), .busy(busy), .done(done));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0, ocnt = 0;
   int first_c = 0, last_c = 0, done_c = 0;
   bit busy_at_done = 1'b0, timed_out = 1'b0, finished = 1'b0;
   int src_re [NM], src_im [NM];
   int res_re [32], res_im [32];
   int exp_re [NM], exp_im [NM];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (out_valid) begin
         if (ocnt < 32) begin
            res_re[ocnt] = int'(out_re);
            res_im[ocnt] = int'(out_im);
         end
         if (ocnt == 0) first_c = cyc;
         last_c = cyc;
         ocnt++;
      end
      if (done) begin
         done_c = cyc;
         busy_at_done = busy;
      end
   end

   task automatic chk(input string tag, input int got, input int expv);
      checks++;
      if (got != expv) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, expv);
      end
   endtask

   task automatic wr_cfg(input bit sel, input int a, input int re, input int im);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_addr = ML'(a);
      cfg_re = 16'(re); cfg_im = 16'(im);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rnd(input real v, output int r);
      r = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
   endtask

   // N=4 reference: (1/4) sum x[n] * (-+j)^(nk)
   task automatic dft4(input bit inv);
      for (int k = 0; k < 4; k++) begin
         int sr = 0, si = 0;
         for (int n = 0; n < 4; n++) begin
            int m = (n * k) % 4;
            if (inv && (m % 2 == 1)) m = 4 - m;
            case (m)
               0: begin sr += src_re[n];  si += src_im[n];  end
               1: begin sr += src_im[n];  si -= src_re[n];  end
               2: begin sr -= src_re[n];  si -= src_im[n];  end
               default: begin sr -= src_im[n]; si += src_re[n]; end
            endcase
         end
         exp_re[k] = sr / 4;
         exp_im[k] = si / 4;
      end
   endtask

   task automatic run(input int lg, input int n, input bit inv, input int g,
                      input bit gaps, input bit junk, input bit restart);
      bit tog = 1'b0;
      int fed = 0;
      ocnt = 0; done_c = -1;
      @(negedge clk);
      log_len = 3'(lg); inverse = inv; gain = 5'(g); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (fed < n && cyc < LIMIT) begin
         if (in_ready && !(gaps && tog)) begin
            in_valid = 1'b1; in_re = 16'(src_re[fed]); in_im = 16'(src_im[fed]);
            fed++;
         end else begin
            in_valid = 1'b0;
         end
         start = restart && (fed == 2);
         if (restart && fed == 2) log_len = 3'd1;
         tog = ~tog;
         @(negedge clk);
      end
      start = 1'b0;
      in_valid = junk;
      in_re = 16'sd12345; in_im = -16'sd2222;
      while (!done && cyc < LIMIT) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (cyc >= LIMIT) timed_out = 1'b1;
      chk("R9 result count", ocnt, n);
      chk("R9 consecutive beats", last_c - first_c + 1, n);
      chk("R9 done after last", done_c, last_c + 1);
      chk("R9 busy low at done", int'(busy_at_done), 0);
   endtask

   task automatic cmp_bins(input string tag, input int n);
      for (int k = 0; k < n; k++) begin
         chk($sformatf("%s bin %0d re", tag, k), res_re[k], exp_re[k]);
         chk($sformatf("%s bin %0d im", tag, k), res_im[k], exp_im[k]);
      end
   endtask

   task automatic set_window(input bit half_odd);
      for (int i = 0; i < NM; i++)
         wr_cfg(1'b0, i, (half_odd && i % 2 == 1) ? 8192 : 16384, 0);
   endtask

   task automatic set4(input int a0, b0, a1, b1, a2, b2, a3, b3);
      src_re[0] = a0; src_im[0] = b0; src_re[1] = a1; src_im[1] = b1;
      src_re[2] = a2; src_im[2] = b2; src_re[3] = a3; src_im[3] = b3;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet outputs out of reset
      chk("R1 busy", int'(busy), 0);
      chk("R1 in_ready", int'(in_ready), 0);
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 done", int'(done), 0);
      rst_n = 1'b1;

      for (int t = 0; t < NM / 2; t++) begin
         int cr, ci;
         rnd(16384.0 * $cos(2.0 * 3.14159265358979 * t / NM), cr);
         rnd(-16384.0 * $sin(2.0 * 3.14159265358979 * t / NM), ci);
         wr_cfg(1'b1, t, cr, ci);
      end
      set_window(1'b0);

      // R3 forward length 4
      set4(400, -100, -200, 300, 1000, 40, -60, -800);
      dft4(1'b0);
      run(2, 4, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      cmp_bins("R3 fwd4", 4);

      // R4 inverse length 4, with input gaps (R2)
      dft4(1'b1);
      run(2, 4, 1'b1, 0, 1'b1, 1'b0, 1'b0);
      cmp_bins("R4 inv4 R2 gaps", 4);

      // R5 impulse length 16
      for (int i = 0; i < NM; i++) begin src_re[i] = 0; src_im[i] = 0; end
      src_re[0] = 1600; src_im[0] = -800;
      for (int k = 0; k < NM; k++) begin exp_re[k] = 100; exp_im[k] = -50; end
      run(4, 16, 1'b0, 0, 1'b0, 1'b1, 1'b0);
      cmp_bins("R5 impulse16", 16);

      // R8 clamp above max, constant input
      for (int i = 0; i < NM; i++) begin src_re[i] = 320; src_im[i] = 160; end
      for (int k = 0; k < NM; k++) begin exp_re[k] = 0; exp_im[k] = 0; end
      exp_re[0] = 320; exp_im[0] = 160;
      run(7, 16, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      cmp_bins("R8 clamp-high dc16", 16);

      // R2 stray in_valid while idle, then R8 log_len 0 runs N=2
      @(negedge clk);
      in_valid = 1'b1; in_re = 16'sd9999; in_im = 16'sd7777;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      src_re[0] = 100; src_im[0] = 50; src_re[1] = 40; src_im[1] = -30;
      exp_re[0] = 70; exp_im[0] = 10; exp_re[1] = 30; exp_im[1] = 40;
      run(0, 2, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      cmp_bins("R8 len0 R2 idle-valid", 2);

      // R7 positive gain saturates
      src_re[0] = 20000; src_im[0] = -20000; src_re[1] = 10000; src_im[1] = 4000;
      exp_re[0] = 32767; exp_im[0] = -32000; exp_re[1] = 20000; exp_im[1] = -32768;
      run(1, 2, 1'b0, 2, 1'b0, 1'b0, 1'b0);
      cmp_bins("R7 gain+2", 2);

      // R7 negative gain shifts right
      exp_re[0] = 1875; exp_im[0] = -1000; exp_re[1] = 625; exp_im[1] = -1500;
      run(1, 2, 1'b0, -3, 1'b0, 1'b0, 1'b0);
      cmp_bins("R7 gain-3", 2);

      // R6 window: odd samples weighted by one half
      set_window(1'b1);
      set4(64, -32, 128, 96, -96, 32, 160, -64);
      set4(64, -32, 64, 48, -96, 32, 80, -32);
      dft4(1'b0);
      set4(64, -32, 128, 96, -96, 32, 160, -64);
      run(2, 4, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      cmp_bins("R6 window", 4);
      set_window(1'b0);

      // R10 start during loading with another length is ignored
      set4(400, -100, -200, 300, 1000, 40, -60, -800);
      dft4(1'b0);
      run(2, 4, 1'b0, 0, 1'b0, 1'b0, 1'b1);
      cmp_bins("R10 restart ignored", 4);

      if (timed_out) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule